// File: doc/BRIEF.md
# Stereo Audio Serial Output Port (Slave, I2S / Left-Justified)

This block sends 24-bit stereo samples out on one serial data line. The bit clock and the word clock both come from outside, so the block is always a slave. An upstream filter hands over a left sample and a right sample, each with its own valid strobe. At each word-clock transition the block copies the sample for the channel that is starting into a shadow register. It then shifts that word out MSB first. The data line changes only after falling bit-clock edges, so a receiver can sample it on rising edges.

A static format input selects between I2S framing and left-justified framing. The two framings differ in two ways. The first is which word-clock level marks the left channel. The second is whether the MSB follows the word-clock transition immediately or one bit period later. A hold input freezes both shadow registers, so the last captured pair is sent again and again. Both external clocks are oversampled on the system clock through a synchronizer, and falling bit-clock edges are found by edge detection.

The serializer is a four-state machine:
- IDLE is the state after reset. The line is low, and the machine waits for the first word-clock transition.
- A word-clock transition seen at a falling bit edge moves the machine to SHIFT in left-justified mode, or to LEAD in I2S mode. This happens from any state.
- LEAD sends one zero bit, then moves to SHIFT at the next falling edge.
- SHIFT sends the 24 data bits and moves to PAD after the last one.
- PAD drives zero until the next word-clock transition.

Top module: `aud_serial_tx`

## Requirements
- R1: With `fmt_lj`=0 (I2S), a word clock low marks the left channel and high marks the right channel. The MSB appears at the second falling bit-clock edge after the word-clock transition, which makes the first bit slot of each channel zero.
- R2: With `fmt_lj`=1 (left-justified), a word clock high marks the left channel and low marks the right channel. The MSB appears at the same falling bit-clock edge on which the word clock changes.
- R3: Each channel word is exactly 24 bits and is sent MSB first, on consecutive bit slots.
- R4: `sdata_out` changes only in the system-clock cycle that follows a detected falling bit-clock edge. It is stable at every rising bit-clock edge.
- R5: Every bit slot of a channel frame outside the 24 data slots is driven as zero. This includes the leading I2S slot.
- R6: The word for a channel is fixed at the word-clock transition that starts that channel. A valid strobe that arrives while the word is being shifted does not change the word in flight. It takes effect at that channel's next start.
- R7: While `hold` is 1, neither shadow register updates. The previously captured left/right pair is sent again in every frame, whatever strobes arrive. After `hold` returns to 0, the most recently strobed samples are sent.
- R8: After reset, `sdata_out` is 0 and stays 0 until the first word-clock transition.
- R9: When several valid strobes for one channel arrive before that channel starts, only the last strobed value is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock |
| wclk_in | input | 1 | External word (channel) clock |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| hold | input | 1 | Freeze the shadow registers and repeat the last pair |
| left_data | input | 24 | Left sample from upstream |
| left_vld | input | 1 | Strobe that captures `left_data` |
| right_data | input | 24 | Right sample from upstream |
| right_vld | input | 1 | Strobe that captures `right_data` |
| sdata_out | output | 1 | Serial data, MSB first, left and right multiplexed |

## Verification
The scoreboard decodes the line the way a receiver would. It aligns each channel to the word-clock transition, with the MSB offset and the left-level polarity set by the format. A design that drops the one-bit I2S delay, or swaps the polarity, returns the wrong word or the wrong channel tag.

A left strobe fired in the middle of a left word catches a design that loads the shifter straight from the input instead of at the channel start: that design returns a torn word. Back-to-back strobes catch a design that keeps the first value instead of the last.

Held frames catch shadow registers that keep updating, because the design then sends the new pair too early. The frame after release catches a design that drops strobes taken during the hold. Zero checks on the pad slots catch an LSB that is smeared past slot 24 or a stale bit left on the line.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_PAD   = 2'd3
    } tx_state_e;

    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/aud_tx_stage.sv
module aud_tx_stage #(
    parameter int SAMPLE_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    input  logic [1:0]             vld,
    input  logic [1:0][SAMPLE_W-1:0] din,
    input  logic                   load,
    input  logic                   load_ch,
    output logic [SAMPLE_W-1:0]    ld_word,
    output logic [SAMPLE_W-1:0]    shadow_l,
    output logic [SAMPLE_W-1:0]    shadow_r
);

    logic [SAMPLE_W-1:0] pend [2];
    logic [SAMPLE_W-1:0] shad [2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                pend[c] <= '0;
                shad[c] <= '0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (vld[c]) begin
                    pend[c] <= din[c];
                end
            end
            if (load && !hold) begin
                shad[load_ch] <= pend[load_ch];
            end
        end
    end

    // Word handed to the shifter at a channel start: fresh sample unless frozen.
    assign ld_word  = hold ? shad[load_ch] : pend[load_ch];
    assign shadow_l = shad[aud_tx_pkg::CH_LEFT];
    assign shadow_r = shad[aud_tx_pkg::CH_RIGHT];

endmodule

// File: rtl/aud_tx_serializer.sv
module aud_tx_serializer
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_s,
    input  logic                wclk_s,
    input  logic                fmt_lj,
    input  logic [SAMPLE_W-1:0] ld_word,
    output logic                load,
    output logic                load_ch,
    output logic                bclk_fall,
    output logic                sdata,
    output tx_state_e           state,
    output logic [CNT_W-1:0]    bit_cnt
);

    logic                bclk_prev;
    logic                wclk_last;
    logic                word_edge;
    logic [SAMPLE_W-1:0] shreg;
    tx_state_e           state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_prev <= 1'b0;
            wclk_last <= 1'b0;
        end else begin
            bclk_prev <= bclk_s;
            if (bclk_fall) begin
                wclk_last <= wclk_s;
            end
        end
    end

    assign bclk_fall = bclk_prev & ~bclk_s;
    assign word_edge = bclk_fall && (wclk_s != wclk_last);
    assign load      = word_edge;
    // Channel index 0 is left: left is word clock high in left-justified, low in I2S.
    assign load_ch   = fmt_lj ? ~wclk_s : wclk_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    always_comb begin
        state_n = state;
        if (bclk_fall) begin
            if (word_edge) begin
                state_n = fmt_lj ? ST_SHIFT : ST_LEAD;
            end else begin
                unique case (state)
                    ST_IDLE:  state_n = ST_IDLE;
                    ST_LEAD:  state_n = ST_SHIFT;
                    ST_SHIFT: state_n = (bit_cnt == CNT_W'(SAMPLE_W)) ? ST_PAD : ST_SHIFT;
                    ST_PAD:   state_n = ST_PAD;
                endcase
            end
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata   <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (bclk_fall) begin
            if (word_edge) begin
                if (fmt_lj) begin
                    sdata   <= ld_word[SAMPLE_W-1];
                    shreg   <= {ld_word[SAMPLE_W-2:0], 1'b0};
                    bit_cnt <= CNT_W'(1);
                end else begin
                    sdata   <= 1'b0;
                    shreg   <= ld_word;
                    bit_cnt <= '0;
                end
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        sdata <= 1'b0;
                    end
                    ST_LEAD: begin
                        sdata   <= shreg[SAMPLE_W-1];
                        shreg   <= {shreg[SAMPLE_W-2:0], 1'b0};
                        bit_cnt <= CNT_W'(1);
                    end
                    ST_SHIFT: begin
                        if (bit_cnt == CNT_W'(SAMPLE_W)) begin
                            sdata <= 1'b0;
                        end else begin
                            sdata   <= shreg[SAMPLE_W-1];
                            shreg   <= {shreg[SAMPLE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                    end
                    ST_PAD: begin
                        sdata <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
    parameter int SAMPLE_W    = 24,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                wclk_in,
    input  logic                fmt_lj,
    input  logic                hold,
    input  logic [SAMPLE_W-1:0] left_data,
    input  logic                left_vld,
    input  logic [SAMPLE_W-1:0] right_data,
    input  logic                right_vld,
    output logic                sdata_out
);

    logic [1:0]                clk_sync;
    logic                      load;
    logic                      load_ch;
    logic                      bclk_fall;
    logic [SAMPLE_W-1:0]       ld_word;
    logic [SAMPLE_W-1:0]       sh_l;
    logic [SAMPLE_W-1:0]       sh_r;
    aud_tx_pkg::tx_state_e     fsm_state;
    logic [CNT_W-1:0]          bit_cnt;

    aud_tx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({wclk_in, bclk_in}),
        .dout  (clk_sync)
    );

    aud_tx_stage #(.SAMPLE_W(SAMPLE_W)) stage_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .vld      ({right_vld, left_vld}),
        .din      ({right_data, left_data}),
        .load     (load),
        .load_ch  (load_ch),
        .ld_word  (ld_word),
        .shadow_l (sh_l),
        .shadow_r (sh_r)
    );

    aud_tx_serializer #(.SAMPLE_W(SAMPLE_W)) ser_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_s    (clk_sync[0]),
        .wclk_s    (clk_sync[1]),
        .fmt_lj    (fmt_lj),
        .ld_word   (ld_word),
        .load      (load),
        .load_ch   (load_ch),
        .bclk_fall (bclk_fall),
        .sdata     (sdata_out),
        .state     (fsm_state),
        .bit_cnt   (bit_cnt)
    );

endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(SAMPLE_W + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bclk_fall,
    input logic                sdata,
    input logic                hold,
    input tx_state_e           state,
    input logic [CNT_W-1:0]    bit_cnt,
    input logic [SAMPLE_W-1:0] sh_l,
    input logic [SAMPLE_W-1:0] sh_r
);

    // R4
    sdata_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_fall |=> $stable(sdata));

    // R5
    zero_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> (sdata == 1'b0));

    // R3
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(SAMPLE_W));

    // R3
    shift_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (bit_cnt != '0));

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(sh_l) && $stable(sh_r)));

endmodule

bind aud_serial_tx aud_serial_tx_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_fall (bclk_fall),
    .sdata     (sdata_out),
    .hold      (hold),
    .state     (fsm_state),
    .bit_cnt   (bit_cnt),
    .sh_l      (sh_l),
    .sh_r      (sh_r)
);

// File: tb/aud_serial_tx_tb_top.sv
module aud_serial_tx_tb_top;

    localparam int W     = 24;
    localparam int SLOTS = 32;
    localparam int HALF  = 8;
    localparam int WD    = 150000;

    typedef struct {
        bit          left;
        logic [W-1:0] d;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bclk = 1'b1;
    logic         wclk = 1'b0;
    logic         fmt_lj = 1'b1;
    logic         hold = 1'b0;
    logic [W-1:0] left_data = '0;
    logic         left_vld = 1'b0;
    logic [W-1:0] right_data = '0;
    logic         right_vld = 1'b0;
    logic         sdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_en = 0;

    exp_t q[$];

    always #5 clk = ~clk;

    aud_serial_tx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_in    (bclk),
        .wclk_in    (wclk),
        .fmt_lj     (fmt_lj),
        .hold       (hold),
        .left_data  (left_data),
        .left_vld   (left_vld),
        .right_data (right_data),
        .right_vld  (right_vld),
        .sdata_out  (sdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_l(input logic [W-1:0] v);
        @(negedge clk); left_data = v; left_vld = 1'b1;
        @(negedge clk); left_vld = 1'b0;
    endtask

    task automatic put_r(input logic [W-1:0] v);
        @(negedge clk); right_data = v; right_vld = 1'b1;
        @(negedge clk); right_vld = 1'b0;
    endtask

    // One channel half-frame of SLOTS bit clocks; word clock moves with the first falling edge.
    task automatic run_half(input logic lvl, input bit mid_upd, input logic [W-1:0] mid_val);
        for (int i = 0; i < SLOTS; i++) begin
            @(negedge clk); bclk = 1'b0;
            if (i == 0) wclk = lvl;
            repeat (HALF - 1) @(negedge clk);
            @(negedge clk); bclk = 1'b1;
            if (mid_upd && i == 10) begin
                left_data = mid_val; left_vld = 1'b1;
                @(negedge clk); left_vld = 1'b0;
                repeat (HALF - 2) @(negedge clk);
            end else begin
                repeat (HALF - 1) @(negedge clk);
            end
        end
    endtask

    // Driver: pushes the expected pair, then plays one frame (left half first).
    task automatic run_frame(input logic [W-1:0] el, input logic [W-1:0] er,
                             input bit mid_upd, input logic [W-1:0] mid_val);
        exp_t e;
        e.left = 1'b1; e.d = el; q.push_back(e);
        e.left = 1'b0; e.d = er; q.push_back(e);
        run_half(fmt_lj ? 1'b1 : 1'b0, mid_upd, mid_val);
        run_half(fmt_lj ? 1'b0 : 1'b1, 1'b0, '0);
    endtask

    task automatic preamble();
        mon_en = 0;
        run_half(fmt_lj ? 1'b0 : 1'b1, 1'b0, '0);
        mon_en = 1;
    endtask

    // Monitor: decodes the line as a receiver on rising bit-clock edges.
    int           slot = 0;
    logic         prev_w = 1'b0;
    logic [W-1:0] acc = '0;
    bit           pad_bad = 0;

    always @(posedge bclk) begin
        int   off;
        exp_t e;
        bit   is_left;
        if (rst_n) begin
            if (wclk != prev_w) begin
                slot = 0; acc = '0; pad_bad = 0; prev_w = wclk;
            end else begin
                slot++;
            end
            off = fmt_lj ? 0 : 1;
            is_left = fmt_lj ? wclk : !wclk;
            if (slot >= off && slot < off + W) begin
                acc = {acc[W-2:0], sdata};
                if (slot == off + W - 1 && mon_en) begin
                    if (q.size() == 0) begin
                        check(0, "R3 unexpected word", {8'h0, acc}, 32'h0);
                    end else begin
                        e = q.pop_front();
                        check(e.left == is_left, fmt_lj ? "R2 channel polarity" : "R1 channel polarity",
                              {31'h0, is_left}, {31'h0, e.left});
                        check(acc == e.d, fmt_lj ? "R2/R3 word" : "R1/R3 word",
                              {8'h0, acc}, {8'h0, e.d});
                    end
                end
            end else if (sdata !== 1'b0) begin
                pad_bad = 1;
            end
            if (slot == SLOTS - 1 && mon_en) begin
                check(!pad_bad, "R5 pad slots zero", {31'h0, pad_bad}, 32'h0);
            end
        end
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(sdata == 1'b0, "R8 line low in reset", {31'h0, sdata}, 32'h0);
        rst_n = 1'b1;
        // R8: bit clock runs, word clock constant: line must stay low.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); bclk = 1'b0;
            repeat (HALF - 1) @(negedge clk);
            @(negedge clk); bclk = 1'b1;
            check(sdata == 1'b0, "R8 idle before first word edge", {31'h0, sdata}, 32'h0);
            repeat (HALF - 1) @(negedge clk);
        end

        // Left-justified: R2, R3, R6
        fmt_lj = 1'b1;
        put_l(24'hA5C3F1); put_r(24'h123456);
        preamble();
        run_frame(24'hA5C3F1, 24'h123456, 1'b1, 24'h0F0F0F);   // R6 mid-word strobe
        run_frame(24'h0F0F0F, 24'h123456, 1'b0, '0);           // R6 new value next frame
        // R9: last strobe wins
        put_l(24'h111111); put_l(24'h800001); put_r(24'hFFFFFF);
        run_frame(24'h800001, 24'hFFFFFF, 1'b0, '0);
        // R7: hold repeats last pair
        put_l(24'h2468AC); put_r(24'hDB9753);
        run_frame(24'h2468AC, 24'hDB9753, 1'b0, '0);
        hold = 1'b1;
        put_l(24'h765432); put_r(24'h00FF00);
        run_frame(24'h2468AC, 24'hDB9753, 1'b0, '0);
        run_frame(24'h2468AC, 24'hDB9753, 1'b0, '0);
        hold = 1'b0;
        run_frame(24'h765432, 24'h00FF00, 1'b0, '0);           // R7 release
        mon_en = 0;

        // I2S: R1, R3, R5, R6
        fmt_lj = 1'b0;
        put_l(24'hAAAAAA); put_r(24'h555555);
        preamble();
        run_frame(24'hAAAAAA, 24'h555555, 1'b0, '0);
        put_l(24'hFFFFFF); put_r(24'h000001);
        run_frame(24'hFFFFFF, 24'h000001, 1'b1, 24'h3C3C3C);   // R6 in I2S
        run_frame(24'h3C3C3C, 24'h000001, 1'b0, '0);
        mon_en = 0;

        check(q.size() == 0, "R3 all words received", q.size(), 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule